// File: doc/BRIEF.md
# I2C Target Packet Check Guard

This block runs next to the byte engine of an I2C target. The engine reports bus framing and byte events: a fresh START, a repeated START, a STOP, and each byte with a flag that says whether the controller sent it or the target sent it. From these events the block keeps a CRC-8 over every address, command and data byte of the transaction. START, repeated START, STOP and acknowledge bits are not part of the CRC.

A write has the form address, command, data and an optional check byte. The command and data bytes are held in staging registers. At STOP the block decides whether to commit the write, using three configuration bits: `cfg_en` turns checking on, `cfg_req` makes the check byte mandatory, and `cfg_irq_en` allows a rejected write to raise the interrupt. If the check byte does not match, the block NACKs that byte. A missing check byte under `cfg_req` is still acknowledged on the bus, but the write is discarded.

On a read the block outputs the running CRC together with a flag. The flag tells the engine whether to send that CRC as a trailing byte after the register data.

Top module: `pec_guard`

## Requirements
- R1: `pec_byte` is the CRC-8 (polynomial 0x07, MSB first, no reflection, no final XOR) of every byte reported since the last START, starting from 0x00. It is updated in the cycle after each byte. A repeated START does not restart it. If events coincide, START takes priority over repeated START, repeated START over STOP, and STOP over a byte.
- R2: In the cycle after each byte sent by the controller (`ev_dir`=0), `ack_vld` is 1 for exactly one cycle. `ack`=1 means ACK and `ack`=0 means NACK. Bytes sent by the target (`ev_dir`=1) produce no `ack_vld`.
- R3: With `cfg_en`=0, a write (first byte bit 0 = 0) that has a data byte when STOP arrives is committed, `pec_append` stays 0 and `irq_n` never falls. In this mode a fourth received byte is NACKed.
- R4: With `cfg_en`=1 and `cfg_req`=0, a write ending at STOP directly after its data byte is committed, and `irq_n` stays high.
- R5: With `cfg_en`=1, a fourth write byte that differs from `pec_byte` is NACKed, and the write is not committed.
- R6: With `cfg_en`=1 and `cfg_req`=1, a write with no check byte is not committed, and every byte of it is still ACKed.
- R7: `irq_n` falls in the cycle after STOP ends a write rejected by R5 or R6, but only when all three configuration bits are 1. It stays low until `irq_clr` is pulsed. If a new rejection and `irq_clr` occur in the same cycle, the rejection wins.
- R8: A check byte that matches is ACKed. `commit` then pulses for one cycle, in the cycle after STOP.
- R9: `pec_append` equals `cfg_en` (delayed by one cycle) while the transaction is a read, meaning its latest address byte had bit 0 = 1. It is 0 at all other times.
- R10: Received bytes after the fourth byte of a write are NACKed and do not change the commit decision. A repeated START abandons a staged write. A write that stops before its data byte commits nothing and raises no interrupt.
- R11: While `commit` is high, `commit_reg` and `commit_data` carry the second and third bytes of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Enable packet checking |
| cfg_req | input | 1 | Check byte mandatory on writes |
| cfg_irq_en | input | 1 | Allow rejected writes to raise the interrupt |
| irq_clr | input | 1 | Pulse to release the interrupt |
| ev_start | input | 1 | START seen |
| ev_rstart | input | 1 | Repeated START seen |
| ev_stop | input | 1 | STOP seen |
| ev_byte | input | 1 | A byte was transferred |
| ev_dir | input | 1 | 0: controller sent the byte, 1: target sent it |
| ev_data | input | 8 | Byte value |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| commit | output | 1 | One-cycle write commit strobe |
| commit_reg | output | 8 | Register index of the committed write |
| commit_data | output | 8 | Data of the committed write |
| pec_byte | output | 8 | Running CRC of the transaction |
| pec_append | output | 1 | Engine should send `pec_byte` after read data |
| irq_n | output | 1 | Sticky active-low interrupt |

## Verification
The bench covers the four write outcomes (matching, wrong and missing check byte, plus checking disabled) under every relevant setting of the policy bits. A design that merged the missing and wrong cases would either NACK a missing byte or commit a write that `cfg_req` forbids. Read transactions with a repeated START check that the CRC keeps the write-phase bytes; a design that cleared the CRC on the repeated START would return the wrong check byte. Other tests cover bytes past the check byte, a write abandoned by a repeated START, and a clear that arrives together with a new rejection. These catch a design that commits stale staging, acknowledges junk, or loses an interrupt.

// File: rtl/pec_guard_pkg.sv
package pec_guard_pkg;
  localparam int BYTE_W = 8;
  localparam int POS_W  = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  // Positions within a write, counted from the address byte
  localparam logic [POS_W-1:0] POS_ADDR = 3'd0;
  localparam logic [POS_W-1:0] POS_REG  = 3'd1;
  localparam logic [POS_W-1:0] POS_DATA = 3'd2;
  localparam logic [POS_W-1:0] POS_CHK  = 3'd3;

  function automatic byte_t crc_fold(input byte_t crc, input byte_t b, input byte_t poly);
    byte_t c;
    c = crc;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (c[BYTE_W-1] ^ b[i]) c = {c[BYTE_W-2:0], 1'b0} ^ poly;
      else                    c = {c[BYTE_W-2:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/pec_crc_acc.sv
module pec_crc_acc
  import pec_guard_pkg::*;
#(
  parameter byte_t POLY = 8'h07,
  parameter byte_t INIT = 8'h00
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  fold,
  input  byte_t din,
  output byte_t crc_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)  crc_q <= INIT;
    else if (fold)   crc_q <= crc_fold(crc_q, din, POLY);
  end

  // R1
  clr_init_chk: assert property (@(posedge clk) disable iff (rst) clr |=> (crc_q == INIT));
endmodule

// File: rtl/pec_frame_track.sv
module pec_frame_track
  import pec_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             stop,
  input  logic             byte_v,
  input  logic             byte_dir,
  input  byte_t            byte_d,
  output logic [POS_W-1:0] pos,
  output logic             wr_mode,
  output logic             rd_mode,
  output logic             have_data,
  output byte_t            stg_reg,
  output byte_t            stg_data
);
  localparam logic [POS_W-1:0] POS_SAT = '1;

  logic rx;
  assign rx = byte_v && !byte_dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      wr_mode   <= 1'b0;
      rd_mode   <= 1'b0;
      have_data <= 1'b0;
      stg_reg   <= '0;
      stg_data  <= '0;
    end else if (restart || stop) begin
      pos       <= '0;
      wr_mode   <= 1'b0;
      rd_mode   <= 1'b0;
      have_data <= 1'b0;
    end else if (byte_v) begin
      if (pos != POS_SAT) pos <= pos + 1'b1;
      if (rx && pos == POS_ADDR) begin
        wr_mode <= ~byte_d[0];
        rd_mode <= byte_d[0];
      end
      if (rx && wr_mode && pos == POS_REG) stg_reg <= byte_d;
      if (rx && wr_mode && pos == POS_DATA) begin
        stg_data  <= byte_d;
        have_data <= 1'b1;
      end
    end
  end

  // R10
  mode_excl_chk: assert property (@(posedge clk) disable iff (rst) !(wr_mode && rd_mode));
  // R10
  restart_drop_chk: assert property (@(posedge clk) disable iff (rst) restart |=> !have_data);
endmodule

// File: rtl/pec_policy.sv
module pec_policy
  import pec_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_req,
  input  logic             cfg_irq_en,
  input  logic             irq_clr,
  input  logic             restart,
  input  logic             stop,
  input  logic             byte_v,
  input  logic             byte_dir,
  input  byte_t            byte_d,
  input  logic [POS_W-1:0] pos,
  input  logic             wr_mode,
  input  logic             have_data,
  input  byte_t            crc_q,
  input  byte_t            stg_reg,
  input  byte_t            stg_data,
  output logic             ack_vld,
  output logic             ack,
  output logic             commit,
  output byte_t            commit_reg,
  output byte_t            commit_data,
  output logic             irq_n
);
  logic chk_seen, chk_bad;
  logic rx, is_chk, is_extra, chk_mis, nack;
  logic decide, accept, reject, irq_set;

  assign rx       = byte_v && !byte_dir;
  assign is_chk   = wr_mode && cfg_en && (pos == POS_CHK);
  assign is_extra = wr_mode && ((pos > POS_CHK) || ((pos == POS_CHK) && !cfg_en));
  assign chk_mis  = byte_d != crc_q;
  assign nack     = is_extra || (is_chk && chk_mis);

  assign decide = stop && wr_mode && have_data;
  always_comb begin
    accept = 1'b0;
    if (decide) begin
      if (!cfg_en)       accept = 1'b1;
      else if (chk_seen) accept = !chk_bad;
      else               accept = !cfg_req;
    end
  end
  assign reject  = decide && !accept;
  assign irq_set = reject && cfg_en && cfg_req && cfg_irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_seen    <= 1'b0;
      chk_bad     <= 1'b0;
      ack_vld     <= 1'b0;
      ack         <= 1'b0;
      commit      <= 1'b0;
      commit_reg  <= '0;
      commit_data <= '0;
      irq_n       <= 1'b1;
    end else begin
      ack_vld <= rx;
      ack     <= rx && !nack;
      commit  <= accept;
      if (accept) begin
        commit_reg  <= stg_reg;
        commit_data <= stg_data;
      end
      if (restart || stop) begin
        chk_seen <= 1'b0;
        chk_bad  <= 1'b0;
      end else if (rx && is_chk) begin
        chk_seen <= 1'b1;
        chk_bad  <= chk_mis;
      end
      if (irq_set)      irq_n <= 1'b0;
      else if (irq_clr) irq_n <= 1'b1;
    end
  end

  // R2
  ack_src_chk: assert property (@(posedge clk) disable iff (rst) ack_vld |-> $past(byte_v && !byte_dir));
  // R8
  commit_pulse_chk: assert property (@(posedge clk) disable iff (rst) commit |=> !commit);
  // R8
  commit_stop_chk: assert property (@(posedge clk) disable iff (rst) commit |-> $past(stop));
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst) (!irq_n && !irq_clr) |=> !irq_n);
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(cfg_en && cfg_req && cfg_irq_en && stop));
endmodule

// File: rtl/pec_guard.sv
module pec_guard
  import pec_guard_pkg::*;
#(
  parameter logic [7:0] CRC_POLY = 8'h07,
  parameter logic [7:0] CRC_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_en,
  input  logic       cfg_req,
  input  logic       cfg_irq_en,
  input  logic       irq_clr,
  input  logic       ev_start,
  input  logic       ev_rstart,
  input  logic       ev_stop,
  input  logic       ev_byte,
  input  logic       ev_dir,
  input  logic [7:0] ev_data,
  output logic       ack_vld,
  output logic       ack,
  output logic       commit,
  output logic [7:0] commit_reg,
  output logic [7:0] commit_data,
  output logic [7:0] pec_byte,
  output logic       pec_append,
  output logic       irq_n
);
  logic             rs_q, stop_q, byte_q, restart;
  logic [POS_W-1:0] pos;
  logic             wr_mode, rd_mode, have_data;
  byte_t            stg_reg, stg_data, crc_q;

  // Event priority: START > repeated START > STOP > byte
  assign rs_q    = ev_rstart && !ev_start;
  assign stop_q  = ev_stop && !ev_start && !ev_rstart;
  assign byte_q  = ev_byte && !ev_start && !ev_rstart && !ev_stop;
  assign restart = ev_start || rs_q;

  pec_crc_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst(rst), .clr(ev_start), .fold(byte_q), .din(ev_data), .crc_q(crc_q)
  );

  pec_frame_track u_track (
    .clk(clk), .rst(rst), .restart(restart), .stop(stop_q),
    .byte_v(byte_q), .byte_dir(ev_dir), .byte_d(ev_data),
    .pos(pos), .wr_mode(wr_mode), .rd_mode(rd_mode), .have_data(have_data),
    .stg_reg(stg_reg), .stg_data(stg_data)
  );

  pec_policy u_policy (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_req(cfg_req), .cfg_irq_en(cfg_irq_en),
    .irq_clr(irq_clr), .restart(restart), .stop(stop_q),
    .byte_v(byte_q), .byte_dir(ev_dir), .byte_d(ev_data),
    .pos(pos), .wr_mode(wr_mode), .have_data(have_data), .crc_q(crc_q),
    .stg_reg(stg_reg), .stg_data(stg_data),
    .ack_vld(ack_vld), .ack(ack), .commit(commit),
    .commit_reg(commit_reg), .commit_data(commit_data), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) pec_append <= 1'b0;
    else     pec_append <= cfg_en && rd_mode;
  end
  assign pec_byte = crc_q;

  // R9
  append_en_chk: assert property (@(posedge clk) disable iff (rst) pec_append |-> $past(cfg_en));
endmodule

// File: tb/pec_guard_tb.sv
module pec_guard_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_en = 0, cfg_req = 0, cfg_irq_en = 0, irq_clr = 0;
  logic ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_byte = 0, ev_dir = 0;
  logic [7:0] ev_data = 0;
  logic ack_vld, ack, commit, pec_append, irq_n;
  logic [7:0] commit_reg, commit_data, pec_byte;

  int vectors = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pec_guard u_dut (.*);

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    int v;
    v = int'(c ^ b);
    repeat (8) begin
      v = v << 1;
      if ((v & 'h100) != 0) v = v ^ 'h107;
    end
    return v[7:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, advanced at each rising edge
  int m_crc, m_pos, m_irq = 1;
  bit m_wr, m_rd, m_hd, m_seen, m_bad;
  int m_reg, m_data;
  bit e_ackv, e_ack, e_commit, e_app, e_irq = 1;
  int e_creg, e_cdata;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_crc = 0; m_pos = 0; m_wr = 0; m_rd = 0; m_hd = 0; m_seen = 0; m_bad = 0;
      e_ackv = 0; e_ack = 0; e_commit = 0; e_app = 0; e_irq = 1; e_creg = 0; e_cdata = 0;
      m_reg = 0; m_data = 0;
    end else begin
      bit st, rs, sp, by, rx, bad, ok;
      st = ev_start; rs = ev_rstart && !st; sp = ev_stop && !st && !rs;
      by = ev_byte && !st && !rs && !sp; rx = by && !ev_dir;
      e_app = cfg_en && m_rd;
      e_ackv = rx;
      bad = 0;
      if (m_wr && (m_pos > 3 || (m_pos == 3 && !cfg_en))) bad = 1;
      if (m_wr && m_pos == 3 && cfg_en && int'(ev_data) != m_crc) bad = 1;
      e_ack = rx && !bad;
      e_commit = 0;
      if (sp && m_wr && m_hd) begin
        ok = !cfg_en ? 1 : (m_seen ? !m_bad : !cfg_req);
        e_commit = ok;
        if (ok) begin e_creg = m_reg; e_cdata = m_data; end
        if (!ok && cfg_en && cfg_req && cfg_irq_en) e_irq = 0;
        else if (irq_clr) e_irq = 1;
      end else if (irq_clr) e_irq = 1;
      if (rx && m_wr && m_pos == 3 && cfg_en) begin
        m_seen = 1; m_bad = (int'(ev_data) != m_crc);
      end
      if (rx && m_wr && m_pos == 1) m_reg = ev_data;
      if (rx && m_wr && m_pos == 2) begin m_data = ev_data; m_hd = 1; end
      if (rx && m_pos == 0) begin m_wr = !ev_data[0]; m_rd = ev_data[0]; end
      if (st) m_crc = 0;
      else if (by) m_crc = ref_crc(m_crc[7:0], ev_data);
      if (by && m_pos < 7) m_pos++;
      if (st || rs || sp) begin
        m_pos = 0; m_wr = 0; m_rd = 0; m_hd = 0; m_seen = 0; m_bad = 0;
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 ack_vld", ack_vld, e_ackv);
      check("R2 ack", ack, e_ack);
      check("R8 commit", commit, e_commit);
      if (e_commit) begin
        check("R11 commit_reg", commit_reg, e_creg);
        check("R11 commit_data", commit_data, e_cdata);
      end
      check("R7 irq_n", irq_n, e_irq);
      check("R1 pec_byte", pec_byte, m_crc);
      check("R9 pec_append", pec_append, e_app);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic ev(input int kind, input logic [7:0] d = 8'h00, input logic dir = 1'b0);
    @(negedge clk);
    ev_start = (kind == 0); ev_rstart = (kind == 1); ev_stop = (kind == 2);
    ev_byte = (kind == 3); ev_data = d; ev_dir = dir;
    @(negedge clk);
    ev_start = 0; ev_rstart = 0; ev_stop = 0; ev_byte = 0; ev_dir = 0;
  endtask

  // mode: 0 missing check, 1 good check, 2 bad check, 3 good check plus extra byte
  task automatic wr_txn(input logic [7:0] r, input logic [7:0] d, input int mode,
                        input int exp_ack_chk, input int exp_commit, input int exp_irq,
                        input string tag);
    logic [7:0] c;
    c = ref_crc(ref_crc(ref_crc(8'h00, 8'hA0), r), d);
    ev(0);
    ev(3, 8'hA0); check({tag, " addr ack"}, ack, 1);
    ev(3, r);     check({tag, " reg ack"}, ack, 1);
    ev(3, d);     check({tag, " data ack"}, ack, 1);
    if (mode != 0) begin
      ev(3, (mode == 2) ? (c ^ 8'h01) : c);
      check({tag, " check ack"}, ack, exp_ack_chk);
      if (mode == 3) begin ev(3, 8'h77); check("R10 extra byte nack", ack, 0); end
    end
    ev(2);
    check({tag, " commit"}, commit, exp_commit);
    if (exp_commit != 0) begin
      check("R11 reg", commit_reg, r);
      check("R11 data", commit_data, d);
    end
    ev(4);
    check({tag, " irq_n"}, irq_n, exp_irq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R2 reset ack_vld", ack_vld, 0);
    check("R8 reset commit", commit, 0);
    check("R7 reset irq_n", irq_n, 1);
    check("R1 reset pec", pec_byte, 0);

    // Checking disabled
    cfg_en = 0; cfg_req = 1; cfg_irq_en = 1;
    wr_txn(8'h12, 8'h34, 0, 1, 1, 1, "R3 disabled");
    wr_txn(8'h13, 8'h35, 1, 0, 1, 1, "R3 disabled 4th byte");

    // Optional check byte
    cfg_en = 1; cfg_req = 0; cfg_irq_en = 1;
    wr_txn(8'h21, 8'h9C, 1, 1, 1, 1, "R8 good");
    wr_txn(8'h22, 8'h01, 0, 1, 1, 1, "R4 missing");
    wr_txn(8'h23, 8'hFF, 2, 0, 0, 1, "R5 bad no irq");
    wr_txn(8'h24, 8'h00, 3, 1, 1, 1, "R10 extra");

    // Mandatory check byte, interrupt off
    cfg_req = 1; cfg_irq_en = 0;
    wr_txn(8'h31, 8'h5A, 0, 1, 0, 1, "R6 missing");
    wr_txn(8'h32, 8'hA5, 2, 0, 0, 1, "R5 bad req");
    wr_txn(8'h33, 8'h66, 1, 1, 1, 1, "R8 good req");

    // Interrupt on
    cfg_irq_en = 1;
    wr_txn(8'h41, 8'h10, 2, 0, 0, 0, "R7 bad irq");
    repeat (5) @(negedge clk);
    check("R7 sticky", irq_n, 0);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    check("R7 cleared", irq_n, 1);
    wr_txn(8'h42, 8'h20, 0, 1, 0, 0, "R7 missing irq");
    // Clear together with a new rejection: set wins
    ev(0); ev(3, 8'hA0); ev(3, 8'h43); ev(3, 8'h30);
    @(negedge clk);
    ev_stop = 1; irq_clr = 1;
    @(negedge clk);
    ev_stop = 0; irq_clr = 0;
    check("R7 set beats clear", irq_n, 0);
    irq_clr = 1; @(negedge clk); irq_clr = 0;

    // Short write and write abandoned by repeated START
    ev(0); ev(3, 8'hA0); ev(3, 8'h50); ev(2);
    check("R10 short write no commit", commit, 0);
    ev(4); check("R10 short write no irq", irq_n, 1);
    ev(0); ev(3, 8'hA0); ev(3, 8'h51); ev(3, 8'h52); ev(1); ev(2);
    check("R10 rstart abandons", commit, 0);

    // Read with check byte
    begin
      logic [7:0] c;
      c = ref_crc(ref_crc(ref_crc(ref_crc(8'h00, 8'hA0), 8'h07), 8'hA1), 8'h5A);
      ev(0); ev(3, 8'hA0); ev(3, 8'h07); ev(1); ev(3, 8'hA1); ev(3, 8'h5A, 1'b1);
      check("R2 tx byte no ack", ack_vld, 0);
      check("R1 read pec spans rstart", pec_byte, c);
      check("R9 append on", pec_append, 1);
      ev(2); @(negedge clk);
      check("R9 append off after stop", pec_append, 0);
      cfg_en = 0;
      ev(0); ev(3, 8'hA1); ev(3, 8'h5A, 1'b1); @(negedge clk);
      check("R3 no append when disabled", pec_append, 0);
      ev(2);
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule